// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked requester and an external asynchronous static RAM of 8192 eight-bit words. Each accepted request becomes one complete, correctly timed memory cycle on the chip pins. The pins are a 13-bit address, an active-low chip enable, an active-high chip enable, and active-low output and write enables. The bidirectional data bus appears as three plain signals: a driven value, a drive enable and a sampled input. The tri-state pad cell sits outside the block.

Every phase length is a whole number of clock cycles. Each length is worked out at elaboration from the clock period and the nanosecond minimums, rounding up. With the default 10 ns clock, a write takes 5 cycles: 1 setup cycle, 3 cycles with the write enable low, and 1 hold cycle. A read takes 8 cycles: 6 access cycles and 2 bus-turnaround cycles.

The request side is valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Under back-pressure (`req_ready` low), the requester must hold `req_valid` and the payload until the edge where the request is accepted. After acceptance the payload may change freely, because the controller has latched it. The response side has no back-pressure: `rsp_valid` is a one-cycle strobe that the consumer must take when it appears.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: In reset and whenever idle, the pins are in their idle state: `sram_ce_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_oe_n`=1 and `sram_dq_oe`=0. At the same time `req_ready`=1 and `rsp_valid`=0.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for every cycle of the memory cycle that follows. Address, write data and write flag are taken from the accepting edge only; changes on those inputs afterwards have no effect on the pins.
- R3: A write (`req_write`=1) has three phases. First, 1 setup cycle: enables active, `sram_we_n`=1 and data driven (`sram_dq_oe`=1). Second, 3 cycles with `sram_we_n`=0. Third, 1 hold cycle with `sram_we_n`=1 and data still driven. The controller is idle, with `req_ready`=1, in the cycle after the hold cycle.
- R4: The address stays constant for as long as the chip enables are active. The driven data and the address stay unchanged from the first write-enable-low cycle through the hold cycle.
- R5: `sram_oe_n` stays 1 throughout a write. `sram_we_n` is 0 only while `sram_ce_n`=0 and `sram_ce2`=1.
- R6: A read (`req_write`=0) holds `sram_ce_n`=0, `sram_ce2`=1, `sram_oe_n`=0 and `sram_we_n`=1 for 6 cycles, with `sram_dq_oe`=0. `sram_dq_in` is sampled at the clock edge that ends the 6th cycle.
- R7: `rsp_valid` is high for exactly one cycle, the cycle right after the last access cycle, and `rsp_rdata` carries the sampled value in that cycle. A write never raises `rsp_valid`.
- R8: After a read, 2 turnaround cycles with idle pins and an undriven bus come before `req_ready` returns. The data bus is never driven while `sram_oe_n`=0, and never within 2 cycles of `sram_oe_n` rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read data |
| sram_addr | output | 13 | Memory address pins |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_ce2 | output | 1 | Chip enable, active high |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | 8 | Value for the data pad to drive |
| sram_dq_oe | output | 1 | Data pad drive enable |
| sram_dq_in | input | 8 | Value sampled from the data pad |

## Verification
The assertions take for granted a requester that holds `req_valid` and the payload stable until acceptance. They also assume that nothing but the controller starts memory cycles. The stimulus keeps to this: each request is raised just after a clock edge, held until the bench sees it accepted, and then the payload inputs are deliberately scrambled while the controller is busy. The memory model outside the block returns a junk value until the read enables have been active for the full access time. Any early capture of read data therefore shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_PULSE,
    ST_W_HOLD,
    ST_W_REC,
    ST_R_ACCESS,
    ST_R_TURN
  } sram_state_e;

  // nanoseconds to clock cycles, rounded up
  function automatic int ns2cyc(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len_m1,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= len_m1;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_C = 1,
  parameter int PULSE_C = 3,
  parameter int HOLD_C  = 1,
  parameter int REC_C   = 0,
  parameter int ACC_C   = 6,
  parameter int TURN_C  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  output logic        req_ready,
  output sram_state_e state_q,
  output sram_state_e state_d,
  output logic        phase_last
);

  localparam int MAXLEN = imax(imax(imax(SETUP_C, PULSE_C), imax(HOLD_C, REC_C)),
                               imax(ACC_C, TURN_C));
  localparam int CW = $clog2(MAXLEN + 1);

  function automatic int phase_len(input sram_state_e s);
    case (s)
      ST_W_SETUP:  return SETUP_C;
      ST_W_PULSE:  return PULSE_C;
      ST_W_HOLD:   return HOLD_C;
      ST_W_REC:    return imax(REC_C, 1);
      ST_R_ACCESS: return ACC_C;
      ST_R_TURN:   return TURN_C;
      default:     return 1;
    endcase
  endfunction

  logic          start;
  logic [CW-1:0] len_m1;

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (req_valid) state_d = req_write ? ST_W_SETUP : ST_R_ACCESS;
      ST_W_SETUP:  if (phase_last) state_d = ST_W_PULSE;
      ST_W_PULSE:  if (phase_last) state_d = ST_W_HOLD;
      ST_W_HOLD:   if (phase_last) state_d = (REC_C > 0) ? ST_W_REC : ST_IDLE;
      ST_W_REC:    if (phase_last) state_d = ST_IDLE;
      ST_R_ACCESS: if (phase_last) state_d = ST_R_TURN;
      ST_R_TURN:   if (phase_last) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign start  = (state_d != state_q);
  assign len_m1 = CW'(phase_len(state_d) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  sram_phase_timer #(.CW(CW)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .len_m1 (len_m1),
    .last   (phase_last)
  );

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready) |=> (state_q != ST_IDLE || $past(phase_last))); // R2

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int AW     = 13,
  parameter int DW     = 8,
  parameter int TURN_C = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  sram_state_e   state_q,
  input  sram_state_e   state_d,
  input  logic          phase_last,
  input  logic [DW-1:0] sram_dq_in,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_ce2,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  localparam int GW = $clog2(TURN_C + 1) + 1;

  logic sel_d, we_d, oe_d, drv_d;

  always_comb begin
    sel_d = (state_d == ST_W_SETUP) || (state_d == ST_W_PULSE) ||
            (state_d == ST_W_HOLD)  || (state_d == ST_R_ACCESS);
    we_d  = (state_d == ST_W_PULSE);
    oe_d  = (state_d == ST_R_ACCESS);
    drv_d = (state_d == ST_W_SETUP) || (state_d == ST_W_PULSE) ||
            (state_d == ST_W_HOLD);
  end

  // pins are registered so the board sees clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_ce_n   <= 1'b1;
      sram_ce2    <= 1'b0;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
    end else begin
      if (accept) begin
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
      end
      sram_ce_n  <= !sel_d;
      sram_ce2   <= sel_d;
      sram_we_n  <= !we_d;
      sram_oe_n  <= !oe_d;
      sram_dq_oe <= drv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (state_q == ST_R_ACCESS) && phase_last;
      if ((state_q == ST_R_ACCESS) && phase_last)
        rsp_rdata <= sram_dq_in;
    end
  end

  // checker state: cycles since the output enable was last low
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= GW'(TURN_C);
    else if (!sram_oe_n)       gap_q <= '0;
    else if (gap_q < GW'(TURN_C)) gap_q <= gap_q + 1'b1;
  end

  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n) |-> (!sram_ce_n && sram_ce2 && sram_oe_n)); // R5

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n) |=> (sram_dq_oe && $stable(sram_dq_out) && $stable(sram_addr))); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n) |=> (sram_ce_n || $stable(sram_addr))); // R4

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n) |-> !sram_dq_oe); // R8

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (gap_q >= GW'(TURN_C))); // R8

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R7

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 13,
  parameter int DW      = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WP    = 25,
  parameter int T_WC    = 50,
  parameter int T_AW    = 40,
  parameter int T_SCE1  = 40,
  parameter int T_SCE2  = 30,
  parameter int T_SD    = 25,
  parameter int T_AA    = 55,
  parameter int T_RC    = 55,
  parameter int T_DOE   = 25,
  parameter int T_HZOE  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_ce2,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);

  localparam int PULSE_C = imax(1, ns2cyc(T_WP, CLK_NS));
  localparam int PRE_END = imax(imax(ns2cyc(T_AW, CLK_NS), ns2cyc(T_SD, CLK_NS)),
                                imax(ns2cyc(T_SCE1, CLK_NS), ns2cyc(T_SCE2, CLK_NS)));
  localparam int SETUP_C = imax(1, PRE_END - PULSE_C);
  localparam int HOLD_C  = 1;
  localparam int REC_C   = imax(0, ns2cyc(T_WC, CLK_NS) - SETUP_C - PULSE_C - HOLD_C);
  localparam int ACC_C   = imax(1, imax(ns2cyc(T_AA, CLK_NS),
                                        imax(ns2cyc(T_RC, CLK_NS), ns2cyc(T_DOE, CLK_NS))));
  localparam int TURN_C  = imax(1, ns2cyc(T_HZOE, CLK_NS));

  sram_state_e state_q, state_d;
  logic        phase_last;
  logic        accept;

  assign accept = req_valid && req_ready;

  sram_cycle_seq #(
    .SETUP_C (SETUP_C), .PULSE_C (PULSE_C), .HOLD_C (HOLD_C),
    .REC_C   (REC_C),   .ACC_C   (ACC_C),   .TURN_C (TURN_C)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .state_q    (state_q),
    .state_d    (state_d),
    .phase_last (phase_last)
  );

  sram_pin_drive #(.AW(AW), .DW(DW), .TURN_C(TURN_C)) pins_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .state_q     (state_q),
    .state_d     (state_d),
    .phase_last  (phase_last),
    .sram_dq_in  (sram_dq_in),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_ce2    (sram_ce2),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && !sram_ce2 && sram_we_n && sram_oe_n && !sram_dq_oe)); // R1

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_SETUP = 1, N_PULSE = 3, N_HOLD = 1, N_ACC = 6, N_TURN = 2;
  localparam logic [7:0] JUNK = 8'h5A;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [12:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [12:0] sram_addr;
  logic sram_ce_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0] sram_dq_out;
  logic [7:0] sram_dq_in = JUNK;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_ce2(sram_ce2), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  typedef struct {
    bit ce_n, ce2, we_n, oe_n, dq_oe, rv;
    logic [12:0] a;
    logic [7:0]  d;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  logic [7:0] ref_mem[int];
  logic [7:0] dev_mem[int];
  int checks = 0, failures = 0;
  int rd_cnt = 0;
  logic [12:0] rd_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic exp_t mk(bit ce, bit we, bit oe, bit drv, bit rv,
                              logic [12:0] a, logic [7:0] d, string tag);
    exp_t e;
    e.ce_n = !ce; e.ce2 = ce; e.we_n = !we; e.oe_n = !oe; e.dq_oe = drv;
    e.rv = rv; e.a = a; e.d = d; e.tag = tag;
    return e;
  endfunction

  function automatic logic [7:0] ref_rd(input logic [12:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
  endfunction

  // reference model, compared every cycle at the falling edge
  always @(negedge clk) begin
    exp_t e;
    logic [4:0] act_ctl, exp_ctl;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(req_ready == 1'b0, "R2 busy", {31'd0, req_ready}, 0);
    end else begin
      e = mk(0, 0, 0, 0, 0, '0, '0, "R1 idle");
      chk(req_ready == 1'b1, "R1 ready", {31'd0, req_ready}, 1);
    end
    act_ctl = {sram_ce_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe};
    exp_ctl = {e.ce_n, e.ce2, e.we_n, e.oe_n, e.dq_oe};
    chk(act_ctl == exp_ctl, e.tag, {27'd0, act_ctl}, {27'd0, exp_ctl});
    if (!e.ce_n) chk(sram_addr == e.a, "R2 R4 addr", {19'd0, sram_addr}, {19'd0, e.a});
    if (e.dq_oe) chk(sram_dq_out == e.d, "R2 R4 data", {24'd0, sram_dq_out}, {24'd0, e.d});
    chk(rsp_valid == e.rv, "R7 valid", {31'd0, rsp_valid}, {31'd0, e.rv});
    if (e.rv) chk(rsp_rdata == e.d, "R7 rdata", {24'd0, rsp_rdata}, {24'd0, e.d});

    if (rst_n && req_valid && req_ready) begin
      if (req_write) begin
        for (int i = 0; i < N_SETUP; i++) exp_q.push_back(mk(1, 0, 0, 1, 0, req_addr, req_wdata, "R3 R5 setup"));
        for (int i = 0; i < N_PULSE; i++) exp_q.push_back(mk(1, 1, 0, 1, 0, req_addr, req_wdata, "R3 R5 pulse"));
        for (int i = 0; i < N_HOLD; i++)  exp_q.push_back(mk(1, 0, 0, 1, 0, req_addr, req_wdata, "R3 R5 hold"));
        ref_mem[int'(req_addr)] = req_wdata;
      end else begin
        for (int i = 0; i < N_ACC; i++) exp_q.push_back(mk(1, 0, 1, 0, 0, req_addr, '0, "R6 access"));
        exp_q.push_back(mk(0, 0, 0, 0, 1, '0, ref_rd(req_addr), "R8 turn"));
        for (int i = 1; i < N_TURN; i++) exp_q.push_back(mk(0, 0, 0, 0, 0, '0, '0, "R8 turn"));
      end
    end

    // external memory model with access delay
    if (!sram_we_n && !sram_ce_n && sram_ce2 && sram_dq_oe)
      dev_mem[int'(sram_addr)] = sram_dq_out;
    if (!sram_ce_n && sram_ce2 && !sram_oe_n && sram_we_n) begin
      rd_cnt = (rd_cnt > 0 && rd_addr == sram_addr) ? rd_cnt + 1 : 1;
      rd_addr = sram_addr;
    end else rd_cnt = 0;
    if (rd_cnt >= N_ACC)
      sram_dq_in <= dev_mem.exists(int'(rd_addr)) ? dev_mem[int'(rd_addr)] : 8'h00;
    else
      sram_dq_in <= JUNK;
  end

  task automatic send(input bit w, input logic [12:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!(req_valid && req_ready));
    @(posedge clk); #1;
    req_valid = 0; req_write = !w; req_addr = ~a; req_wdata = ~d; // R2 scramble
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    send(1, 13'h0000, 8'h11);
    send(1, 13'h1FFF, 8'hA7);
    send(0, 13'h1FFF, 8'h00);
    send(0, 13'h0000, 8'h00);
    send(1, 13'h0123, 8'h3C);     // write right after read: R8 turnaround
    send(0, 13'h0123, 8'h00);
    send(0, 13'h0777, 8'h00);     // never written
    repeat (3) @(posedge clk);
    send(1, 13'h0AAA, 8'hFF);
    send(1, 13'h1555, 8'h00);
    send(0, 13'h0AAA, 8'h00);
    send(0, 13'h1555, 8'h00);
    for (int i = 0; i < 24; i++) begin
      logic [7:0] dv;
      dv = 8'((i * 37 + 1) & 255);
      if (dv == JUNK) dv = dv + 1;
      send(i[0], 13'((i * 331) & 8191), dv);
      if (i % 5 == 0) repeat (2) @(posedge clk);
    end
    for (int i = 0; i < 24; i++) send(0, 13'((i * 331) & 8191), 8'h00);
    repeat (12) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule